// File: doc/BRIEF.md
# Full-Duplex Four-Phase Link Endpoint

This block terminates one point-to-point link of an on-chip network. It serves the port between a network interface and a router, and the port between two neighbouring routers. A flit goes out on the outgoing wire set and a flit comes in on the incoming wire set. Each direction uses its own four-phase request/acknowledge handshake:

1. The sender raises req with the data.
2. The receiver raises ack.
3. The sender drops req.
4. The receiver drops ack.

A transfer is complete only when req and ack are both low again, so a level on the wires always has one meaning.

The transmit path and the receive path each have their own synchronous state machine. The two machines share a clock and never wait on each other, so both directions can be busy in the same cycle.

- **Transmit side.** Flits arrive from upstream over a valid/ready pair. The transmitter takes a new flit only when it is idle and the far end's ack is low.
- **Receive side.** The receiver captures an incoming flit and offers it downstream over a valid/accept pair. It keeps its ack high until the flit has been taken, which gives backpressure toward the sender.

Top module: `hs_link_port`

## Requirements
- R1: While rst_ni is low, link_req_o, link_ack_o and rx_valid_o are 0. With link_ack_i low, tx_ready_o is 1.
- R2: tx_ready_o is 1 only when the transmitter has no transfer in progress and link_ack_i is 0.
- R3: When tx_valid_i and tx_ready_o are both 1 at a clock edge, link_req_o is 1 after that edge and link_data_o equals the tx_flit_i that was sampled there.
- R4: While link_req_o stays high, link_data_o does not change, even if tx_flit_i changes with tx_valid_i held high.
- R5: link_req_o falls at the first clock edge at which link_ack_i is seen high while req is high.
- R6: After req falls, tx_ready_o stays 0 until link_ack_i has been sampled low. Upstream flits offered before then are not sent.
- R7: When link_req_i is 1 while link_ack_o is 0, then after the next edge link_ack_o and rx_valid_o are 1 and rx_flit_o equals the sampled link_data_i.
- R8: link_ack_o stays 1 for as long as rx_valid_o is 1.
- R9: link_ack_o falls at the first edge at which link_req_i is 0 and the flit has been delivered (accepted at that edge or earlier). While link_req_i is still 1, link_ack_o stays 1.
- R10: Both directions run concurrently. An outgoing and an incoming transfer can overlap in any phase without delaying each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Upstream flit offered |
| tx_flit_i | input | W | Upstream flit |
| tx_ready_o | output | 1 | Transmitter can take a flit |
| link_req_o | output | 1 | Outgoing request wire |
| link_data_o | output | W | Outgoing data wire |
| link_ack_i | input | 1 | Acknowledge from the far receiver |
| link_req_i | input | 1 | Incoming request wire |
| link_data_i | input | W | Incoming data wire |
| link_ack_o | output | 1 | Acknowledge to the far sender |
| rx_valid_o | output | 1 | Received flit available downstream |
| rx_flit_o | output | W | Received flit |
| rx_accept_i | input | 1 | Downstream takes the flit |

## Verification
The assertions assume the far end follows the four-phase rules:

- link_ack_i rises only while link_req_o is high, and falls only after req has fallen.
- link_req_i rises only while link_ack_o is low, and falls only after ack has risen.
- link_data_i is stable from the rise of req until ack is seen.

The stimulus plays the far sender and the far receiver and keeps to these rules by construction. It varies the response delays and the order of delivery against req release across a full sweep. The only input that breaks a rule on purpose is the upstream valid, which is held high with changing data while the transmitter is busy, to show that it is ignored.

// File: rtl/hs_link_pkg.sv
`timescale 1ns/1ps
package hs_link_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_REQ  = 2'd1,
    TX_REL  = 2'd2
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_FULL = 2'd1,
    RX_DONE = 2'd2
  } rx_state_e;
endpackage

// File: rtl/hs_link_tx.sv
`timescale 1ns/1ps
module hs_link_tx
  import hs_link_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] flit_i,
  output logic         ready_o,
  output logic         req_o,
  output logic [W-1:0] data_o,
  input  logic         ack_i
);
  tx_state_e    st_q, st_d;
  logic         req_q;
  logic [W-1:0] data_q;

  assign ready_o = (st_q == TX_IDLE) && !ack_i;
  assign req_o   = req_q;
  assign data_o  = data_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      TX_IDLE: if (valid_i && ready_o) st_d = TX_REQ;
      TX_REQ:  if (ack_i)              st_d = TX_REL;
      TX_REL:  if (!ack_i)             st_d = TX_IDLE;
      default:                         st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      req_q  <= 1'b0;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == TX_IDLE && st_d == TX_REQ) begin
        req_q  <= 1'b1;
        data_q <= flit_i;
      end else if (st_q == TX_REQ && st_d == TX_REL) begin
        req_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hs_link_rx.sv
`timescale 1ns/1ps
module hs_link_rx
  import hs_link_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [W-1:0] data_i,
  output logic         ack_o,
  output logic         valid_o,
  output logic [W-1:0] flit_o,
  input  logic         accept_i
);
  rx_state_e    st_q, st_d;
  logic         ack_q;
  logic         valid_q;
  logic [W-1:0] flit_q;
  logic         take;

  assign take    = valid_q && accept_i;
  assign ack_o   = ack_q;
  assign valid_o = valid_q;
  assign flit_o  = flit_q;

  // FULL: flit not yet taken; DONE: taken, waiting for req to fall
  always_comb begin
    st_d = st_q;
    case (st_q)
      RX_IDLE: if (req_i) st_d = RX_FULL;
      RX_FULL: begin
        if (take) st_d = req_i ? RX_DONE : RX_IDLE;
      end
      RX_DONE: if (!req_i) st_d = RX_IDLE;
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      flit_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == RX_IDLE && st_d == RX_FULL) begin
        flit_q  <= data_i;
        ack_q   <= 1'b1;
        valid_q <= 1'b1;
      end else begin
        if (take)              valid_q <= 1'b0;
        if (st_d == RX_IDLE)   ack_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hs_link_port.sv
`timescale 1ns/1ps
module hs_link_port #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tx_valid_i,
  input  logic [W-1:0] tx_flit_i,
  output logic         tx_ready_o,
  output logic         link_req_o,
  output logic [W-1:0] link_data_o,
  input  logic         link_ack_i,
  input  logic         link_req_i,
  input  logic [W-1:0] link_data_i,
  output logic         link_ack_o,
  output logic         rx_valid_o,
  output logic [W-1:0] rx_flit_o,
  input  logic         rx_accept_i
);
  hs_link_tx #(.W(W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (tx_valid_i),
    .flit_i  (tx_flit_i),
    .ready_o (tx_ready_o),
    .req_o   (link_req_o),
    .data_o  (link_data_o),
    .ack_i   (link_ack_i)
  );

  hs_link_rx #(.W(W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (link_req_i),
    .data_i   (link_data_i),
    .ack_o    (link_ack_o),
    .valid_o  (rx_valid_o),
    .flit_o   (rx_flit_o),
    .accept_i (rx_accept_i)
  );
endmodule

// File: rtl/hs_link_port_chk.sv
`timescale 1ns/1ps
module hs_link_port_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tx_valid_i,
  input logic [W-1:0] tx_flit_i,
  input logic         tx_ready_o,
  input logic         link_req_o,
  input logic [W-1:0] link_data_o,
  input logic         link_ack_i,
  input logic         link_req_i,
  input logic [W-1:0] link_data_i,
  input logic         link_ack_o,
  input logic         rx_valid_o,
  input logic [W-1:0] rx_flit_o,
  input logic         rx_accept_i
);
  a_r2_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (!link_req_o && !link_ack_i));

  a_r3_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> (link_req_o && link_data_o == $past(tx_flit_i)));

  a_r4_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_req_o && $past(link_req_o)) |-> $stable(link_data_o));

  a_r5_req_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_req_o && link_ack_i) |=> !link_req_o);

  a_r6_no_early_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_req_o) |-> !tx_ready_o);

  a_r7_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_req_i && !link_ack_o) |=> (link_ack_o && rx_valid_o && rx_flit_o == $past(link_data_i)));

  a_r8_ack_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> link_ack_o);

  a_r9_ack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_ack_o && !link_req_i && (!rx_valid_o || rx_accept_i)) |=> !link_ack_o);

  a_r9_ack_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_ack_o && link_req_i) |=> link_ack_o);
endmodule

bind hs_link_port hs_link_port_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_valid_i  (tx_valid_i),
  .tx_flit_i   (tx_flit_i),
  .tx_ready_o  (tx_ready_o),
  .link_req_o  (link_req_o),
  .link_data_o (link_data_o),
  .link_ack_i  (link_ack_i),
  .link_req_i  (link_req_i),
  .link_data_i (link_data_i),
  .link_ack_o  (link_ack_o),
  .rx_valid_o  (rx_valid_o),
  .rx_flit_o   (rx_flit_o),
  .rx_accept_i (rx_accept_i)
);

// File: tb/sim_hs_link_port.sv
`timescale 1ns/1ps
module sim_hs_link_port;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tx_valid_i = 1'b0;
  logic [W-1:0] tx_flit_i = '0;
  logic         tx_ready_o;
  logic         link_req_o;
  logic [W-1:0] link_data_o;
  logic         link_ack_i = 1'b0;
  logic         link_req_i = 1'b0;
  logic [W-1:0] link_data_i = '0;
  logic         link_ack_o;
  logic         rx_valid_o;
  logic [W-1:0] rx_flit_o;
  logic         rx_accept_i = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hs_link_port #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .tx_valid_i(tx_valid_i), .tx_flit_i(tx_flit_i), .tx_ready_o(tx_ready_o),
    .link_req_o(link_req_o), .link_data_o(link_data_o), .link_ack_i(link_ack_i),
    .link_req_i(link_req_i), .link_data_i(link_data_i), .link_ack_o(link_ack_o),
    .rx_valid_o(rx_valid_o), .rx_flit_o(rx_flit_o), .rx_accept_i(rx_accept_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // far receiver of our outgoing link; ack answers after d idle cycles
  task automatic run_tx(input logic [W-1:0] f, input int d);
    @(negedge clk);
    chk(tx_ready_o, "R2 ready when idle", tx_ready_o, 1);
    tx_valid_i = 1'b1;
    tx_flit_i  = f;
    @(negedge clk);
    chk(link_req_o, "R3 req raised", link_req_o, 1);
    chk(link_data_o == f, "R3 data", link_data_o, f);
    chk(!tx_ready_o, "R2 busy", tx_ready_o, 0);
    tx_flit_i = ~f;  // valid held: must be ignored
    for (int k = 0; k < d; k++) begin
      @(negedge clk);
      chk(link_req_o, "R4 req held", link_req_o, 1);
      chk(link_data_o == f, "R4 data stable", link_data_o, f);
    end
    link_ack_i = 1'b1;
    @(negedge clk);
    chk(!link_req_o, "R5 req dropped", link_req_o, 0);
    chk(!tx_ready_o, "R6 ready low while ack high", tx_ready_o, 0);
    tx_valid_i = 1'b0;
    link_ack_i = 1'b0;
    @(negedge clk);
    chk(tx_ready_o, "R6 ready after release", tx_ready_o, 1);
    chk(!link_req_o, "R6 no flit taken while busy", link_req_o, 0);
  endtask

  // far sender into our incoming link; accept after a cycles
  task automatic run_rx(input logic [W-1:0] g, input int a, input bit acc_first);
    @(negedge clk);
    link_req_i  = 1'b1;
    link_data_i = g;
    @(negedge clk);
    chk(link_ack_o, "R7 ack raised", link_ack_o, 1);
    chk(rx_valid_o, "R7 valid raised", rx_valid_o, 1);
    chk(rx_flit_o == g, "R7 flit", rx_flit_o, g);
    link_data_i = ~g;
    if (!acc_first) link_req_i = 1'b0;
    for (int k = 0; k < a; k++) begin
      @(negedge clk);
      chk(link_ack_o && rx_valid_o, "R8 ack held until delivered", link_ack_o, 1);
      chk(rx_flit_o == g, "R8 flit held", rx_flit_o, g);
    end
    rx_accept_i = 1'b1;
    @(negedge clk);
    rx_accept_i = 1'b0;
    chk(!rx_valid_o, "R9 delivered", rx_valid_o, 0);
    if (acc_first) begin
      chk(link_ack_o, "R9 ack kept while req high", link_ack_o, 1);
      link_req_i = 1'b0;
      @(negedge clk);
    end
    chk(!link_ack_o, "R9 ack released", link_ack_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!link_req_o, "R1 req reset", link_req_o, 0);
    chk(!link_ack_o, "R1 ack reset", link_ack_o, 0);
    chk(!rx_valid_o, "R1 valid reset", rx_valid_o, 0);
    chk(tx_ready_o, "R1 ready reset", tx_ready_o, 1);
    rst_ni = 1'b1;
    for (int d = 0; d < 4; d++) begin
      for (int a = 0; a < 4; a++) begin
        for (int m = 0; m < 2; m++) begin
          logic [W-1:0] f, g;
          f = W'(16'h1357 + d * 16'h0101 + a * 16'h1010 + m);
          g = W'(16'hC0DE ^ (a * 16'h0303 + d * 16'h3030 + m * 16'h8001));
          // R10: both directions in flight together
          fork
            run_tx(f, d);
            run_rx(g, a, m[0]);
            begin
              @(negedge clk);
              @(negedge clk);
              chk(link_req_o && link_ack_o, "R10 both directions active", {link_req_o, link_ack_o}, 2'b11);
            end
          join
          @(negedge clk);
        end
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule